// File: doc/BRIEF.md
# Configurable Trigger Condition Evaluator

This block reaches one accept-or-reject verdict for each bunch crossing. On every crossing clock it receives a wide, fully synchronous bus of 24 sub-trigger words, each 32 bits wide. Any word slot may carry a physics quantity, for example:

- a muon candidate value
- an electron, photon, neutral-pion or hadron transverse energy
- the summed transverse energy
- a pile-up figure

Sixteen comparator units each pick one word. A unit may optionally add a second word to it, with the sum saturating. It then tests the result against its own programmed threshold using greater-than, equal or less-than. Several units may watch the same word with different thresholds. Eight conditions each AND together a chosen subset of comparator results. The verdict is the OR of the enabled conditions that fired.

All selection is held in registers, so the trigger algorithm can change without rebuilding the logic. Software writes a shadow copy through a simple write port. A commit strobe moves the shadow copy into the active copy at a crossing boundary, so no verdict ever mixes old and new settings. A two-state configuration machine records whether the shadow copy differs from the active copy:

- CFG_SYNCED moves to CFG_PENDING on a write without commit (transition "edit").
- CFG_PENDING moves back to CFG_SYNCED on commit (transition "apply").
- A write together with a commit in CFG_SYNCED applies the edit and stays in CFG_SYNCED (transition "edit-and-apply").
- Every other cycle holds the current state (transition "hold").

Register map (address `cfg_addr`, 8 bits):

| Address | Register | Fields |
|---|---|---|
| 0x00+i | Comparator i control | bits 4:0 first word select; bits 9:5 second word select; bit 10 second-word enable; bits 12:11 operator |
| 0x10+i | Comparator i threshold | 32-bit threshold |
| 0x20+j | Condition j | bits 15:0 comparator mask; bit 16 enable |

Top module: `trig_decision_top`

## Requirements
- R1: After reset, `dec_valid`, `dec_accept` and `dec_hits` are 0. The active configuration is cleared, so a crossing gives a valid verdict with accept 0.
- R2: `dec_valid` equals `xing_valid` delayed by exactly two clock cycles. While `dec_valid` is 0, `dec_accept` and `dec_hits` are 0.
- R3: Operator code 00 fires when the value is greater than the threshold, 01 when it is equal, and 10 when it is less. Code 11 never fires.
- R4: Word select k (0..23) picks bits [32k+31:32k] of `xing_words`. A select of 24 or above reads as value 0.
- R5: With control bit 10 set, the second selected word is added to the first before comparison, and the sum saturates at 0xFFFFFFFF. With bit 10 clear, the second select has no effect.
- R6: A condition fires only when its enable bit is set, its mask is nonzero, and every comparator in its mask fires. A zero mask or a cleared enable never fires.
- R7: `dec_hits` bit j is 1 exactly when condition j fired. `dec_accept` is the OR of the `dec_hits` bits.
- R8: Register writes only change the shadow copy until `cfg_commit`. A crossing sampled on the same edge as the commit uses the old settings, and the next crossing uses the new ones. A write on the commit edge is included in what is applied.
- R9: Several comparators may select the same word, each with its own threshold, and each gives its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xing_valid | input | 1 | A crossing is presented this cycle |
| xing_words | input | 768 | 24 sub-trigger words, word k at bits [32k+31:32k] |
| cfg_we | input | 1 | Shadow register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_commit | input | 1 | Copy the shadow settings to the active settings |
| dec_valid | output | 1 | Verdict valid |
| dec_accept | output | 1 | Accept verdict |
| dec_hits | output | 8 | Conditions that fired |

## Verification
A crossing presented before clock edge k has its comparator results registered at edge k. Its verdict appears at edge k+1. The bench therefore drives on the falling edge and reads the verdict two falling edges later. It also reads once after a single edge to confirm that nothing is valid yet. Commit timing is checked by presenting one crossing together with the commit strobe and a second crossing one cycle later, then reading the two verdicts on consecutive falling edges.

// File: rtl/trig_pkg.sv
package trig_pkg;
    parameter int WORD_W = 32;
    parameter int NWORDS = 24;
    parameter int NCMP   = 16;
    parameter int NCOND  = 8;
    parameter int SEL_W  = $clog2(NWORDS + 8);
    parameter int ADDR_W = 8;
    parameter int IDX_W  = $clog2(NCMP);

    typedef enum logic [1:0] {
        OP_GT  = 2'b00,
        OP_EQ  = 2'b01,
        OP_LT  = 2'b10,
        OP_OFF = 2'b11
    } cmp_op_e;

    typedef struct packed {
        logic [SEL_W-1:0]  sel_a;
        logic [SEL_W-1:0]  sel_b;
        logic              b_en;
        cmp_op_e           op;
        logic [WORD_W-1:0] thr;
    } cmp_cfg_t;

    typedef struct packed {
        logic            en;
        logic [NCMP-1:0] mask;
    } cond_cfg_t;

    typedef enum logic {
        CFG_SYNCED  = 1'b0,
        CFG_PENDING = 1'b1
    } cfg_state_e;
endpackage

// File: rtl/trig_cfg_bank.sv
module trig_cfg_bank
    import trig_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [WORD_W-1:0]       cfg_wdata,
    input  logic                    cfg_commit,
    output cmp_cfg_t  [NCMP-1:0]    act_cmp,
    output cond_cfg_t [NCOND-1:0]   act_cond
);
    localparam int REG_W    = ADDR_W - IDX_W;
    localparam int SELB_LSB = SEL_W;
    localparam int BEN_BIT  = 2 * SEL_W;
    localparam int OP_LSB   = 2 * SEL_W + 1;
    localparam logic [REG_W-1:0] RG_CTRL = REG_W'(0);
    localparam logic [REG_W-1:0] RG_THR  = REG_W'(1);
    localparam logic [REG_W-1:0] RG_COND = REG_W'(2);

    cmp_cfg_t  [NCMP-1:0]  sh_cmp,  sh_cmp_nx;
    cond_cfg_t [NCOND-1:0] sh_cond, sh_cond_nx;
    cfg_state_e            st, st_nx;

    logic [REG_W-1:0] region;
    logic [IDX_W-1:0] idx;

    assign region = cfg_addr[ADDR_W-1:IDX_W];
    assign idx    = cfg_addr[IDX_W-1:0];

    // shadow next value
    always_comb begin
        sh_cmp_nx  = sh_cmp;
        sh_cond_nx = sh_cond;
        if (cfg_we) begin
            for (int i = 0; i < NCMP; i++) begin
                if (idx == IDX_W'(i)) begin
                    if (region == RG_CTRL) begin
                        sh_cmp_nx[i].sel_a = cfg_wdata[SEL_W-1:0];
                        sh_cmp_nx[i].sel_b = cfg_wdata[SELB_LSB +: SEL_W];
                        sh_cmp_nx[i].b_en  = cfg_wdata[BEN_BIT];
                        sh_cmp_nx[i].op    = cmp_op_e'(cfg_wdata[OP_LSB +: 2]);
                    end else if (region == RG_THR) begin
                        sh_cmp_nx[i].thr   = cfg_wdata;
                    end
                end
            end
            for (int j = 0; j < NCOND; j++) begin
                if (region == RG_COND && idx == IDX_W'(j)) begin
                    sh_cond_nx[j].mask = cfg_wdata[NCMP-1:0];
                    sh_cond_nx[j].en   = cfg_wdata[NCMP];
                end
            end
        end
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            CFG_SYNCED:  if (cfg_we && !cfg_commit) st_nx = CFG_PENDING;
            CFG_PENDING: if (cfg_commit)            st_nx = CFG_SYNCED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= CFG_SYNCED;
        else        st <= st_nx;
    end

    // outputs: shadow and active banks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_cmp   <= '0;
            sh_cond  <= '0;
            act_cmp  <= '0;
            act_cond <= '0;
        end else begin
            sh_cmp  <= sh_cmp_nx;
            sh_cond <= sh_cond_nx;
            if (cfg_commit && (st == CFG_PENDING || cfg_we)) begin
                act_cmp  <= sh_cmp_nx;
                act_cond <= sh_cond_nx;
            end
        end
    end
endmodule

// File: rtl/trig_cmp_unit.sv
module trig_cmp_unit
    import trig_pkg::*;
(
    input  logic [NWORDS*WORD_W-1:0] words,
    input  cmp_cfg_t                 cfg,
    output logic                     hit
);
    logic [WORD_W-1:0] val_a, val_b, val;
    logic [WORD_W:0]   sum;

    always_comb begin
        val_a = '0;
        val_b = '0;
        for (int k = 0; k < NWORDS; k++) begin
            if (cfg.sel_a == SEL_W'(k)) val_a = words[k*WORD_W +: WORD_W];
            if (cfg.b_en && cfg.sel_b == SEL_W'(k)) val_b = words[k*WORD_W +: WORD_W];
        end
    end

    always_comb begin
        sum = {1'b0, val_a} + {1'b0, val_b};
        val = sum[WORD_W] ? {WORD_W{1'b1}} : sum[WORD_W-1:0];
    end

    always_comb begin
        unique case (cfg.op)
            OP_GT:  hit = (val > cfg.thr);
            OP_EQ:  hit = (val == cfg.thr);
            OP_LT:  hit = (val < cfg.thr);
            OP_OFF: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/trig_cond_eval.sv
module trig_cond_eval
    import trig_pkg::*;
(
    input  logic      [NCMP-1:0]  cmp_hits,
    input  cond_cfg_t [NCOND-1:0] cond,
    output logic      [NCOND-1:0] fired,
    output logic                  any_fired
);
    for (genvar j = 0; j < NCOND; j++) begin : g_cond
        assign fired[j] = cond[j].en && (|cond[j].mask) &&
                          ((cmp_hits & cond[j].mask) == cond[j].mask);
    end

    assign any_fired = |fired;
endmodule

// File: rtl/trig_decision_top.sv
module trig_decision_top
    import trig_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     xing_valid,
    input  logic [NWORDS*WORD_W-1:0] xing_words,
    input  logic                     cfg_we,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [WORD_W-1:0]        cfg_wdata,
    input  logic                     cfg_commit,
    output logic                     dec_valid,
    output logic                     dec_accept,
    output logic [NCOND-1:0]         dec_hits
);
    cmp_cfg_t  [NCMP-1:0]  act_cmp;
    cond_cfg_t [NCOND-1:0] act_cond;
    logic      [NCMP-1:0]  cmp_comb, cmp_q;
    cond_cfg_t [NCOND-1:0] cond_q;
    logic                  s1_valid;
    logic      [NCOND-1:0] fired;
    logic                  any_fired;

    trig_cfg_bank u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_commit (cfg_commit),
        .act_cmp    (act_cmp),
        .act_cond   (act_cond)
    );

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        trig_cmp_unit u_cmp (
            .words (xing_words),
            .cfg   (act_cmp[i]),
            .hit   (cmp_comb[i])
        );
    end

    // stage 1: comparator results with the condition set of the same crossing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            cmp_q    <= '0;
            cond_q   <= '0;
        end else begin
            s1_valid <= xing_valid;
            cmp_q    <= xing_valid ? cmp_comb : '0;
            cond_q   <= act_cond;
        end
    end

    trig_cond_eval u_eval (
        .cmp_hits  (cmp_q),
        .cond      (cond_q),
        .fired     (fired),
        .any_fired (any_fired)
    );

    // stage 2: verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_hits   <= '0;
        end else begin
            dec_valid  <= s1_valid;
            dec_accept <= s1_valid && any_fired;
            dec_hits   <= s1_valid ? fired : '0;
        end
    end
endmodule

// File: rtl/trig_decision_chk.sv
module trig_decision_chk
    import trig_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  xing_valid,
    input logic                  cfg_commit,
    input logic                  dec_valid,
    input logic                  dec_accept,
    input logic [NCOND-1:0]      dec_hits,
    input cmp_cfg_t  [NCMP-1:0]  act_cmp,
    input cond_cfg_t [NCOND-1:0] act_cond
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (!rst_n)         age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (dec_valid == $past(xing_valid, 2)));

    assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_accept && dec_hits == '0));

    assert_accept_any_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_accept == (dec_hits != '0)));

    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && !$past(cfg_commit)) |-> ($stable(act_cmp) && $stable(act_cond)));
endmodule

bind trig_decision_top trig_decision_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .xing_valid (xing_valid),
    .cfg_commit (cfg_commit),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .dec_hits   (dec_hits),
    .act_cmp    (act_cmp),
    .act_cond   (act_cond)
);

// File: tb/trig_decision_top_tb_top.sv
module trig_decision_top_tb_top;
    import trig_pkg::*;

    localparam int CLK_PERIOD = 25;
    localparam int NVEC = 17;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     xing_valid = 1'b0;
    logic [NWORDS*WORD_W-1:0] xing_words = '0;
    logic                     cfg_we = 1'b0;
    logic [ADDR_W-1:0]        cfg_addr = '0;
    logic [WORD_W-1:0]        cfg_wdata = '0;
    logic                     cfg_commit = 1'b0;
    logic                     dec_valid, dec_accept;
    logic [NCOND-1:0]         dec_hits;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_decision_top dut_i (
        .clk(clk), .rst_n(rst_n), .xing_valid(xing_valid), .xing_words(xing_words),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_commit(cfg_commit),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_hits(dec_hits)
    );

    // {ctrl, threshold, word3/word23 value, word7 value, req, expected}
    localparam logic [135:0] VEC [NVEC] = '{
        {32'h003, 32'd100, 32'd101, 32'd0, 4'd3, 4'd1},
        {32'h003, 32'd100, 32'd100, 32'd0, 4'd3, 4'd0},
        {32'h803, 32'd100, 32'd100, 32'd0, 4'd3, 4'd1},
        {32'h803, 32'd100, 32'd99,  32'd0, 4'd3, 4'd0},
        {32'h1003, 32'd100, 32'd99, 32'd0, 4'd3, 4'd1},
        {32'h1003, 32'd100, 32'd100, 32'd0, 4'd3, 4'd0},
        {32'h1803, 32'd0, 32'd5, 32'd0, 4'd3, 4'd0},
        {32'hCE3, 32'd30, 32'd10, 32'd20, 4'd5, 4'd1},
        {32'h4E3, 32'd29, 32'd10, 32'd20, 4'd5, 4'd1},
        {32'h4E3, 32'd30, 32'd10, 32'd20, 4'd5, 4'd0},
        {32'hCE3, 32'hFFFFFFFF, 32'hFFFFFFF0, 32'h20, 4'd5, 4'd1},
        {32'h4E3, 32'hFFFFFFFE, 32'hFFFFFFF0, 32'h20, 4'd5, 4'd1},
        {32'h8E3, 32'd10, 32'd10, 32'd20, 4'd5, 4'd1},
        {32'h819, 32'd0, 32'd5, 32'd5, 4'd4, 4'd1},
        {32'h019, 32'd0, 32'd5, 32'd5, 4'd4, 4'd0},
        {32'h817, 32'd42, 32'd42, 32'd0, 4'd4, 4'd1},
        {32'h807, 32'd42, 32'd0, 32'd42, 4'd4, 4'd1}
    };

    function automatic string req_name(input int r);
        case (r)
            3: return "R3";
            4: return "R4";
            5: return "R5";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic commit();
        @(negedge clk);
        cfg_commit = 1'b1;
        @(negedge clk);
        cfg_commit = 1'b0;
    endtask

    task automatic set_words(input logic [31:0] a, input logic [31:0] b);
        xing_words = '0;
        xing_words[3*WORD_W +: WORD_W]  = a;
        xing_words[7*WORD_W +: WORD_W]  = b;
        xing_words[23*WORD_W +: WORD_W] = a;
    endtask

    // present one crossing, return on the falling edge where its verdict is visible
    task automatic crossing(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        set_words(a, b);
        xing_valid = 1'b1;
        @(negedge clk);
        xing_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_all();
        for (int i = 0; i < NCMP; i++) begin
            wr(8'(i), 32'h1800);
        end
        for (int j = 0; j < NCOND; j++) begin
            wr(8'(8'h20 + j), 32'h0);
        end
        commit();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", {31'd0, dec_valid}, 32'd0);
        chk("R1", {31'd0, dec_accept}, 32'd0);
        chk("R1", {24'd0, dec_hits}, 32'd0);
        crossing(32'd1000, 32'd1000);
        chk("R1", {31'd0, dec_valid}, 32'd1);
        chk("R1", {31'd0, dec_accept}, 32'd0);

        // R2: exact latency, and no verdict without a crossing
        @(negedge clk);
        set_words(32'd1, 32'd1);
        xing_valid = 1'b1;
        @(negedge clk);
        xing_valid = 1'b0;
        chk("R2", {31'd0, dec_valid}, 32'd0);
        @(negedge clk);
        chk("R2", {31'd0, dec_valid}, 32'd1);
        @(negedge clk);
        chk("R2", {31'd0, dec_valid}, 32'd0);

        // table walk on comparator 0, condition 0 = {enable, mask bit 0}
        wr(8'h20, 32'h10001);
        for (int v = 0; v < NVEC; v++) begin
            wr(8'h00, VEC[v][135:104]);
            wr(8'h10, VEC[v][103:72]);
            commit();
            crossing(VEC[v][71:40], VEC[v][39:8]);
            chk(req_name(int'(VEC[v][7:4])), {31'd0, dec_accept}, {31'd0, VEC[v][0]});
            chk(req_name(int'(VEC[v][7:4])), {24'd0, dec_hits}, {31'd0, VEC[v][0]});
        end

        // R8: writes stay in shadow until commit; commit edge boundary
        wr(8'h00, 32'h003);
        wr(8'h10, 32'd100);
        commit();
        wr(8'h10, 32'd200);
        crossing(32'd150, 32'd0);
        chk("R8", {31'd0, dec_accept}, 32'd1);
        @(negedge clk);
        cfg_commit = 1'b1; xing_valid = 1'b1; set_words(32'd150, 32'd0);
        @(negedge clk);
        cfg_commit = 1'b0;
        @(negedge clk);
        xing_valid = 1'b0;
        chk("R8", {31'd0, dec_accept}, 32'd1);
        @(negedge clk);
        chk("R8", {31'd0, dec_accept}, 32'd0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'h10; cfg_wdata = 32'd100; cfg_commit = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; cfg_commit = 1'b0;
        crossing(32'd150, 32'd0);
        chk("R8", {31'd0, dec_accept}, 32'd1);

        // R6: AND of masked comparators, zero mask, enable bit
        clear_all();
        wr(8'h00, 32'h003); wr(8'h10, 32'd10);
        wr(8'h01, 32'h007); wr(8'h11, 32'd10);
        wr(8'h20, 32'h10003);
        commit();
        crossing(32'd20, 32'd5);
        chk("R6", {31'd0, dec_accept}, 32'd0);
        crossing(32'd20, 32'd20);
        chk("R6", {24'd0, dec_hits}, 32'h1);
        wr(8'h20, 32'h10000); commit();
        crossing(32'd20, 32'd20);
        chk("R6", {31'd0, dec_accept}, 32'd0);
        wr(8'h20, 32'h00003); commit();
        crossing(32'd20, 32'd20);
        chk("R6", {24'd0, dec_hits}, 32'h0);

        // R7: OR over several conditions, hit vector positions
        wr(8'h22, 32'h10001);
        wr(8'h25, 32'h10002);
        commit();
        crossing(32'd20, 32'd5);
        chk("R7", {24'd0, dec_hits}, 32'h04);
        chk("R7", {31'd0, dec_accept}, 32'd1);
        crossing(32'd5, 32'd20);
        chk("R7", {24'd0, dec_hits}, 32'h20);
        crossing(32'd20, 32'd20);
        chk("R7", {24'd0, dec_hits}, 32'h24);
        crossing(32'd5, 32'd5);
        chk("R7", {31'd0, dec_accept}, 32'd0);

        // R9: one word, three comparators, three thresholds
        clear_all();
        wr(8'h00, 32'h003); wr(8'h10, 32'd10);
        wr(8'h01, 32'h003); wr(8'h11, 32'd20);
        wr(8'h02, 32'h003); wr(8'h12, 32'd30);
        wr(8'h20, 32'h10001);
        wr(8'h21, 32'h10002);
        wr(8'h22, 32'h10004);
        commit();
        crossing(32'd25, 32'd0);
        chk("R9", {24'd0, dec_hits}, 32'h03);
        crossing(32'd35, 32'd0);
        chk("R9", {24'd0, dec_hits}, 32'h07);
        crossing(32'd5, 32'd0);
        chk("R9", {24'd0, dec_hits}, 32'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule